// File: doc/BRIEF.md
# Digital Clock Oscillator Jitter Attenuator

This block is a fully digital phase-locked loop clocked by a fast internal working clock. A phase accumulator acts as a numerically controlled oscillator. Each wrap of the accumulator emits a one-cycle enable, which is the dejittered 2.048 MHz clock. The loop locks that enable to a reference that software selects: either the clock recovered from the line or an external 2.048 MHz sync clock. On every rising reference edge, the oscillator's phase at that moment is the phase error. A first-order loop filter scales this error with an arithmetic shift and sets the oscillator increment. The size of the shift sets the loop corner. A narrow setting moves the corner down by about a decade, so slow wander still passes through while faster jitter is smoothed.

A divide-by-256 counter on the dejittered enable produces an 8 kHz frame-rate pulse. A loss counter counts output periods since the last reference edge. When the reference has been absent for two periods, the block flags the loss and pulls the increment back to its nominal value. A control input can disable this recentring, so that a gapped reference does not drag the oscillator back to centre on every gap.

Top module: `dco_jitter_atten`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `clk_en_o`, `frame_en_o` and `ref_lost_o` are 0. The accumulator starts at 0 and the increment starts at `NOM_INC`.
- R2: If no reference edge occurs and recentring is enabled, `clk_en_o` pulses once every `2^ACC_W / NOM_INC` working cycles (8 cycles with the bench parameters).
- R3: `ref_sel_i` = 1 selects `sync_ref_i` and `ref_sel_i` = 0 selects `line_ref_i`. Each input passes through two synchronizing flops, and the unselected input has no effect on any output.
- R4: On a rising edge of the selected, synchronized reference, the phase is read as a two's-complement number of ACC_W bits. The next increment becomes `NOM_INC - (phase >>> shift)`, clamped to the range 1 .. `2^ACC_W-1`. `clk_en_o` is the registered carry of the accumulator.
- R5: The shift is `SHIFT_BASE` when `narrow_i` = 0 (2 Hz corner) and `SHIFT_BASE + 3` when `narrow_i` = 1 (0.2 Hz corner).
- R6: `ref_lost_o` goes high once `LOSS_PERIODS` output enables have occurred with no reference edge. It returns low in the cycle after a reference edge.
- R7: When `ref_lost_o` is high, no edge arrives and `centre_dis_i` = 0, the increment is forced to `NOM_INC` in the next cycle.
- R8: When `centre_dis_i` = 1, the increment is held unchanged while the reference is lost.
- R9: `frame_en_o` pulses for one cycle, one cycle after every `FRAME_DIV`-th `clk_en_o` pulse counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate working clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_ref_i | input | 1 | Recovered line clock level |
| sync_ref_i | input | 1 | External 2.048 MHz sync clock level |
| ref_sel_i | input | 1 | Reference select: 1 = sync, 0 = line |
| narrow_i | input | 1 | 1 selects the decade-lower loop corner |
| centre_dis_i | input | 1 | 1 disables recentring on reference loss |
| clk_en_o | output | 1 | Dejittered clock enable, one working cycle wide |
| frame_en_o | output | 1 | Frame-rate enable |
| ref_lost_o | output | 1 | Reference absent for LOSS_PERIODS output periods |

## Verification
The bench builds the block with ACC_W = 10, NOM_INC = 128, SHIFT_BASE = 2, LOSS_PERIODS = 2 and FRAME_DIV = 16. With these values the nominal output period is only eight working cycles, so phase errors, clamping and both corner settings all show up within a few reference periods. The short frame divider wraps many times during the run, which exercises the frame pulse repeatedly. Line and sync references run at different periods so that selection can be told apart at the output, and the references are stopped with recentring both on and off.

// File: rtl/dcoja_pkg.sv
package dcoja_pkg;
  localparam int unsigned NARROW_EXTRA_SHIFT = 3;  // ~3.3 bits for a decade, rounded

  typedef enum logic {
    CORNER_WIDE   = 1'b0,
    CORNER_NARROW = 1'b1
  } corner_e;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_SYNC = 1'b1
  } ref_src_e;
endpackage

// File: rtl/dcoja_ref_sel.sv
module dcoja_ref_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ref_i,
  input  logic sync_ref_i,
  input  logic ref_sel_i,
  output logic edge_o
);
  import dcoja_pkg::*;

  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] synced;
  logic               sel_lvl;
  logic               sel_d_q;

  assign raw[SRC_LINE] = line_ref_i;
  assign raw[SRC_SYNC] = sync_ref_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh_q[SYNC_STAGES-1];
  end

  assign sel_lvl = synced[ref_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d_q <= 1'b0;
    else         sel_d_q <= sel_lvl;
  end

  assign edge_o = sel_lvl & ~sel_d_q;
endmodule

// File: rtl/dcoja_nco.sv
module dcoja_nco #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  output logic [ACC_W-1:0] phase_o,
  output logic             en_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             en_q;

  assign sum = {1'b0, acc_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      en_q  <= sum[ACC_W];
    end
  end

  assign phase_o = acc_q;
  assign en_o    = en_q;
endmodule

// File: rtl/dcoja_loop.sv
module dcoja_loop #(
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned NOM_INC    = 4096,
  parameter int unsigned SHIFT_BASE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [ACC_W-1:0] phase_i,
  input  logic             narrow_i,
  input  logic             lost_i,
  input  logic             centre_dis_i,
  output logic [ACC_W-1:0] freq_o
);
  import dcoja_pkg::*;

  localparam int unsigned SH_MAX = SHIFT_BASE + NARROW_EXTRA_SHIFT;
  localparam int unsigned SH_W   = $clog2(SH_MAX + 1);
  localparam int unsigned EXT_W  = ACC_W + 2;
  localparam logic signed [EXT_W-1:0] NOM_S = EXT_W'(NOM_INC);
  localparam logic signed [EXT_W-1:0] MIN_S = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] MAX_S = {2'b00, {ACC_W{1'b1}}};

  logic [SH_W-1:0]         shamt;
  logic signed [ACC_W-1:0] err;
  logic signed [ACC_W-1:0] corr;
  logic signed [EXT_W-1:0] cand;
  logic [ACC_W-1:0]        steer;
  logic [ACC_W-1:0]        freq_q;

  assign shamt = (corner_e'(narrow_i) == CORNER_NARROW) ? SH_W'(SH_MAX) : SH_W'(SHIFT_BASE);
  assign err   = $signed(phase_i);
  assign corr  = err >>> shamt;
  assign cand  = NOM_S - {{2{corr[ACC_W-1]}}, corr};

  always_comb begin
    if (cand < MIN_S)      steer = ACC_W'(1);
    else if (cand > MAX_S) steer = {ACC_W{1'b1}};
    else                   steer = cand[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     freq_q <= ACC_W'(NOM_INC);
    else if (edge_i)                 freq_q <= steer;
    else if (lost_i && !centre_dis_i) freq_q <= ACC_W'(NOM_INC);
  end

  assign freq_o = freq_q;
endmodule

// File: rtl/dcoja_loss.sv
module dcoja_loss #(
  parameter int unsigned LOSS_PERIODS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic out_en_i,
  output logic lost_o
);
  localparam int unsigned CNT_W = $clog2(LOSS_PERIODS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOSS_PERIODS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (edge_i)                   cnt_q <= '0;
    else if (out_en_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign lost_o = (cnt_q == LIMIT);
endmodule

// File: rtl/dcoja_frame_div.sv
module dcoja_frame_div #(
  parameter int unsigned FRAME_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic frame_o
);
  localparam int unsigned DIV_W = $clog2(FRAME_DIV);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(FRAME_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= en_i && (div_q == LAST);
      if (en_i) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/dco_jitter_atten.sv
module dco_jitter_atten #(
  parameter int unsigned ACC_W        = 16,
  parameter int unsigned NOM_INC      = 4096,
  parameter int unsigned SHIFT_BASE   = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LOSS_PERIODS = 2,
  parameter int unsigned FRAME_DIV    = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ref_i,
  input  logic sync_ref_i,
  input  logic ref_sel_i,
  input  logic narrow_i,
  input  logic centre_dis_i,
  output logic clk_en_o,
  output logic frame_en_o,
  output logic ref_lost_o
);
  logic             ref_edge;
  logic [ACC_W-1:0] phase_w;
  logic [ACC_W-1:0] freq_w;
  logic             en_w;
  logic             lost_w;

  dcoja_ref_sel #(.SYNC_STAGES(SYNC_STAGES)) i_ref_sel (
    .clk_i, .rst_ni, .line_ref_i, .sync_ref_i, .ref_sel_i,
    .edge_o(ref_edge)
  );

  dcoja_nco #(.ACC_W(ACC_W)) i_nco (
    .clk_i, .rst_ni, .freq_i(freq_w), .phase_o(phase_w), .en_o(en_w)
  );

  dcoja_loop #(.ACC_W(ACC_W), .NOM_INC(NOM_INC), .SHIFT_BASE(SHIFT_BASE)) i_loop (
    .clk_i, .rst_ni, .edge_i(ref_edge), .phase_i(phase_w), .narrow_i,
    .lost_i(lost_w), .centre_dis_i, .freq_o(freq_w)
  );

  dcoja_loss #(.LOSS_PERIODS(LOSS_PERIODS)) i_loss (
    .clk_i, .rst_ni, .edge_i(ref_edge), .out_en_i(en_w), .lost_o(lost_w)
  );

  dcoja_frame_div #(.FRAME_DIV(FRAME_DIV)) i_frame (
    .clk_i, .rst_ni, .en_i(en_w), .frame_o(frame_en_o)
  );

  assign clk_en_o   = en_w;
  assign ref_lost_o = lost_w;
endmodule

// File: rtl/dcoja_checker.sv
module dcoja_checker #(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned NOM_INC = 4096
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_en_o,
  input logic             frame_en_o,
  input logic             ref_lost_o,
  input logic             centre_dis_i,
  input logic             ref_edge,
  input logic [ACC_W-1:0] freq_w
);
  AST_FRAME_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_en_o |-> $past(clk_en_o)) else $error("frame without enable"); // R9

  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_en_o |=> !frame_en_o) else $error("frame pulse too wide"); // R9

  AST_RECENTRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_lost_o && !ref_edge && !centre_dis_i) |=> (freq_w == ACC_W'(NOM_INC)))
    else $error("no recentre"); // R7

  AST_GAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_lost_o && !ref_edge && centre_dis_i) |=> $stable(freq_w))
    else $error("increment moved while gapped"); // R8

  AST_LOST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_edge |=> !ref_lost_o) else $error("loss not cleared"); // R6

  AST_FREQ_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_edge |=> (freq_w != '0)) else $error("zero increment"); // R4
endmodule

bind dco_jitter_atten dcoja_checker #(.ACC_W(ACC_W), .NOM_INC(NOM_INC)) i_chk (
  .clk_i, .rst_ni, .clk_en_o, .frame_en_o, .ref_lost_o, .centre_dis_i,
  .ref_edge, .freq_w
);

// File: tb/test_dco_jitter_atten.sv
module test_dco_jitter_atten;
  localparam int W   = 10;
  localparam int NOM = 128;
  localparam int SHB = 2;
  localparam int LP  = 2;
  localparam int FD  = 16;

  logic clk = 0, rst_n = 0;
  logic line_ref = 0, sync_ref = 0, sel = 0, narrow = 0, cdis = 0;
  logic clk_en, frame_en, lost;
  int checks = 0, errors = 0;
  int line_per = 0, sync_per = 0, line_cnt = 0, sync_cnt = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  dco_jitter_atten #(.ACC_W(W), .NOM_INC(NOM), .SHIFT_BASE(SHB),
                     .LOSS_PERIODS(LP), .FRAME_DIV(FD)) i_dco_jitter_atten (
    .clk_i(clk), .rst_ni(rst_n), .line_ref_i(line_ref), .sync_ref_i(sync_ref),
    .ref_sel_i(sel), .narrow_i(narrow), .centre_dis_i(cdis),
    .clk_en_o(clk_en), .frame_en_o(frame_en), .ref_lost_o(lost));

  // reference waveform generators
  always @(negedge clk) begin
    if (line_per > 0) begin
      line_cnt = (line_cnt + 1 >= line_per) ? 0 : line_cnt + 1;
      line_ref <= (line_cnt < line_per / 2);
    end else line_ref <= 0;
    if (sync_per > 0) begin
      sync_cnt = (sync_cnt + 1 >= sync_per) ? 0 : sync_cnt + 1;
      sync_ref <= (sync_cnt < sync_per / 2);
    end else sync_ref <= 0;
  end

  // behavioural reference model
  int m_acc, m_freq, m_cnt, m_div;
  bit m_ls1, m_ls2, m_ys1, m_ys2, m_refd, m_clk, m_frame;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_freq = NOM; m_cnt = 0; m_div = 0;
      {m_ls1, m_ls2, m_ys1, m_ys2, m_refd, m_clk, m_frame} = '0;
    end else begin
      bit rs, rise, mlost, nclk;
      int sum, err, nfreq, sh;
      rs    = sel ? m_ys2 : m_ls2;
      rise  = rs && !m_refd;
      mlost = (m_cnt == LP);
      sum   = m_acc + m_freq;
      nclk  = sum >= (1 << W);
      nfreq = m_freq;
      if (rise) begin
        err   = (m_acc >= (1 << (W - 1))) ? m_acc - (1 << W) : m_acc;
        sh    = SHB + (narrow ? 3 : 0);
        nfreq = NOM - (err >>> sh);
        if (nfreq < 1) nfreq = 1;
        if (nfreq > (1 << W) - 1) nfreq = (1 << W) - 1;
      end else if (mlost && !cdis) nfreq = NOM;
      if (rise) m_cnt = 0;
      else if (m_clk && m_cnt < LP) m_cnt++;
      m_frame = m_clk && (m_div == FD - 1);
      if (m_clk) m_div = (m_div == FD - 1) ? 0 : m_div + 1;
      m_freq = nfreq;
      m_acc  = sum % (1 << W);
      m_clk  = nclk;
      m_refd = rs;
      m_ls2 = m_ls1; m_ls1 = line_ref;
      m_ys2 = m_ys1; m_ys1 = sync_ref;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, clk_en, m_clk, "clk_en_o");
    chk("R9", frame_en, m_frame, "frame_en_o");
    chk("R6", lost, (m_cnt == LP), "ref_lost_o");
  end

  task automatic count_en(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); c += clk_en; end
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk("R1", {clk_en, frame_en, lost}, 0, "outputs in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", {clk_en, frame_en, lost}, 0, "outputs after release");
    cur_req = "R2";
    count_en(160, c);
    chk("R2", c, 20, "nominal enable count");
    chk("R6", lost, 1, "lost with no reference");
    // line reference, sync running differently and unselected
    cur_req = "R4"; line_per = 9; sync_per = 7;
    count_en(400, c);
    chk("R6", lost, 0, "lost cleared while tracking");
    cur_req = "R3"; sel = 1;
    repeat (400) @(negedge clk);
    cur_req = "R5"; narrow = 1;
    repeat (500) @(negedge clk);
    narrow = 0; sel = 0; cur_req = "R4";
    repeat (300) @(negedge clk);
    // loss with recentring
    cur_req = "R7"; line_per = 0; sync_per = 0;
    repeat (60) @(negedge clk);
    chk("R6", lost, 1, "lost after references stop");
    count_en(80, c);
    chk("R7", c, 10, "recentred enable count");
    // gapped reference, recentring disabled
    cur_req = "R4"; line_per = 11;
    repeat (300) @(negedge clk);
    cur_req = "R8"; cdis = 1; line_per = 0;
    repeat (300) @(negedge clk);
    chk("R6", lost, 1, "lost while gapped");
    cur_req = "R3"; cdis = 0; sel = 1; line_per = 9;
    repeat (200) @(negedge clk);
    chk("R3", lost, 1, "unselected line reference ignored");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule